// File: doc/BRIEF.md
# Program Memory Word Access Unit

This unit moves 16-bit words between a word-organised program memory and a group of byte-wide processor registers. Software first loads a byte address into three 8-bit address registers and, for a write, loads the word into a high and a low data byte. It then issues one of four operations: read, read-and-step, write or write-and-step.

A read fetches the word and splits it across the two data bytes. A write joins the two data bytes into one word and stores it. The stepping variants then advance the byte address by two, so a whole block can be copied with one operation per word.

The address is a byte address over word storage. The memory word index is the address shifted right by one. An odd address is refused and raises an alignment error instead of touching memory. The memory side is a plain synchronous port: a read returns data on the clock edge after its request.

Top module: `pmem_word_xfer`

## Requirements
- R1: After reset, `addr_o`, `data_hi_o` and `data_lo_o` are zero, and `op_done`, `align_err`, `mem_re` and `mem_we` are low.
- R2: `op_code[1]` selects the operation: 0 is a read and 1 is a write. `op_code[0]` set selects the stepping variant.
- R3: A read from an even address requests word `addr_o >> 1` on the memory port. The word's bits 15:8 load `data_hi_o` and bits 7:0 load `data_lo_o`. `op_done` pulses for one cycle, rising two clock edges after the edge that samples `op_start`, together with the new data.
- R4: A write to an even address drives `mem_we` for one cycle, beginning at the edge that samples `op_start`. During that cycle `mem_addr` is `addr_o >> 1` and `mem_wdata` is `{data_hi_o, data_lo_o}`. `op_done` pulses one edge later.
- R5: A stepping operation adds 2 to the 24-bit address at the edge that raises `op_done`. A non-stepping operation leaves the address unchanged.
- R6: The step carries across all three address bytes and wraps from 0xFFFFFE to 0x000000.
- R7: When `op_start` arrives while address bit 0 is set, `align_err` pulses for one cycle at the sampling edge. No memory access takes place and no `op_done` follows. Address and data registers are left unchanged.
- R8: When the unit is idle, `reg_we` writes `reg_wdata` into the register chosen by `reg_sel`: 0, 1 and 2 are address bits 7:0, 15:8 and 23:16, 3 is the low data byte and 4 is the high data byte. Register writes are ignored while an operation is in progress or in the cycle `op_start` is sampled.
- R9: An `op_start` that arrives while an operation is in progress is ignored and produces no further `op_done` or memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_start | input | 1 | Single-cycle operation strobe |
| op_code | input | 2 | Bit 1: write; bit 0: step address by 2 |
| reg_we | input | 1 | Direct register write strobe |
| reg_sel | input | 3 | Register select for direct writes |
| reg_wdata | input | 8 | Direct register write data |
| addr_o | output | 24 | Current byte address |
| data_hi_o | output | 8 | High data byte |
| data_lo_o | output | 8 | Low data byte |
| op_done | output | 1 | One-cycle completion pulse |
| align_err | output | 1 | One-cycle misaligned-address pulse |
| mem_addr | output | 23 | Memory word index |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid the edge after `mem_re` |

## Verification
Counted from the edge that samples `op_start`, each result has a fixed due time:
- `align_err` appears at that same edge.
- `mem_we` is active during the following cycle.
- `op_done` for a write follows one edge later.
- `op_done` for a read follows two edges later.

The driver reads a free-running cycle counter before each strobe and stamps every expected item with its due cycle. The monitor samples on falling edges and compares the cycle of each observed event against that stamp, as well as the address, data bytes and memory-port fields. Extra strobes and register writes are issued while an operation is in progress. Any unexpected pulse finds an empty queue and is reported.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_CAP  = 2'd2,
    ST_WR   = 2'd3
  } pmw_state_e;

  localparam int unsigned OP_WRITE_BIT = 1;
  localparam int unsigned OP_STEP_BIT  = 0;
endpackage

// File: rtl/pmw_addr_reg.sv
module pmw_addr_reg #(
  parameter int unsigned NB = 3,
  localparam int unsigned AW = 8 * NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] byte_we,
  input  logic [7:0]    wdata,
  input  logic          step,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] stepped;
  logic [AW-1:0] addr_d;

  assign stepped = addr_q + AW'(2);

  for (genvar i = 0; i < NB; i++) begin : g_byte
    always_comb begin
      if (step) addr_d[8*i +: 8] = stepped[8*i +: 8];
      else if (byte_we[i]) addr_d[8*i +: 8] = wdata;
      else addr_d[8*i +: 8] = addr_q[8*i +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q[8*i +: 8] <= 8'h00;
      else if (step || byte_we[i]) addr_q[8*i +: 8] <= addr_d[8*i +: 8];
    end
  end

  assign addr = addr_q;

  // R5 / R6: a step advances the full address by two, wrapping at the top
  p_step_by_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> addr_q == AW'($past(addr_q) + AW'(2)));
endmodule

// File: rtl/pmw_data_reg.sv
module pmw_data_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [15:0] rdata,
  input  logic [1:0]  byte_we,
  input  logic [7:0]  wdata,
  output logic [7:0]  hi,
  output logic [7:0]  lo
);
  logic [7:0] hi_q, lo_q, hi_d, lo_d;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (load) begin
      hi_d = rdata[15:8];
      lo_d = rdata[7:0];
    end else begin
      if (byte_we[1]) hi_d = wdata;
      if (byte_we[0]) lo_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 8'h00;
      lo_q <= 8'h00;
    end else if (load || (|byte_we)) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;

  // R8: data bytes only change on a load or a direct byte write
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && byte_we == 2'b00) |=> $stable({hi_q, lo_q}));
endmodule

// File: rtl/pmw_ctrl.sv
module pmw_ctrl
  import pmw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op,
  input  logic       misaligned,
  output logic       idle,
  output logic       mem_re,
  output logic       mem_we,
  output logic       load,
  output logic       step,
  output logic       done,
  output logic       err
);
  pmw_state_e state_q, state_d;
  logic       step_q, step_d;
  logic       done_q, done_d;
  logic       err_q, err_d;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    load    = 1'b0;
    step    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (misaligned) begin
            err_d = 1'b1;
          end else begin
            step_d  = op[OP_STEP_BIT];
            state_d = op[OP_WRITE_BIT] ? ST_WR : ST_RD;
          end
        end
      end
      ST_RD: state_d = ST_CAP;
      ST_CAP: begin
        load    = 1'b1;
        step    = step_q;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      ST_WR: begin
        step    = step_q;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign idle   = (state_q == ST_IDLE);
  assign mem_re = (state_q == ST_RD);
  assign mem_we = (state_q == ST_WR);
  assign done   = done_q;
  assign err    = err_q;

  // R7: a misaligned request leaves the unit idle and never completes
  p_misalign_no_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && misaligned) |=> (idle && !done && err));
  // R4: a write cycle is followed by completion
  p_write_completes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> done);
  // R3: a read request completes two edges later
  p_read_completes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> ##1 done);
  // R9: at most one of the outward events at a time
  p_events_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err, mem_we, mem_re}));
endmodule

// File: rtl/pmem_word_xfer.sv
module pmem_word_xfer
  import pmw_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 3,
  localparam int unsigned AW = 8 * ADDR_BYTES,
  localparam int unsigned WAW = AW - 1,
  localparam int unsigned SEL_LO = ADDR_BYTES,
  localparam int unsigned SEL_HI = ADDR_BYTES + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_start,
  input  logic [1:0]     op_code,
  input  logic           reg_we,
  input  logic [2:0]     reg_sel,
  input  logic [7:0]     reg_wdata,
  output logic [AW-1:0]  addr_o,
  output logic [7:0]     data_hi_o,
  output logic [7:0]     data_lo_o,
  output logic           op_done,
  output logic           align_err,
  output logic [WAW-1:0] mem_addr,
  output logic           mem_re,
  output logic           mem_we,
  output logic [15:0]    mem_wdata,
  input  logic [15:0]    mem_rdata
);
  logic [1:0]            rst_sync_q;
  logic                  rst_int_n;
  logic                  idle, load, step, reg_ok;
  logic [ADDR_BYTES-1:0] addr_bwe;
  logic [1:0]            data_bwe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign reg_ok = reg_we && idle && !op_start;

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_abwe
    assign addr_bwe[i] = reg_ok && (reg_sel == 3'(i));
  end
  assign data_bwe[0] = reg_ok && (reg_sel == 3'(SEL_LO));
  assign data_bwe[1] = reg_ok && (reg_sel == 3'(SEL_HI));

  pmw_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (op_start),
    .op         (op_code),
    .misaligned (addr_o[0]),
    .idle       (idle),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .load       (load),
    .step       (step),
    .done       (op_done),
    .err        (align_err)
  );

  pmw_addr_reg #(.NB(ADDR_BYTES)) i_addr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .byte_we (addr_bwe),
    .wdata   (reg_wdata),
    .step    (step),
    .addr    (addr_o)
  );

  pmw_data_reg i_data (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (load),
    .rdata   (mem_rdata),
    .byte_we (data_bwe),
    .wdata   (reg_wdata),
    .hi      (data_hi_o),
    .lo      (data_lo_o)
  );

  assign mem_addr  = addr_o[AW-1:1];
  assign mem_wdata = {data_hi_o, data_lo_o};

  // R8: register writes are refused while an operation runs
  p_no_reg_write_busy_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!idle && !load && !step) |=> $stable({addr_o, data_hi_o, data_lo_o}));
endmodule

// File: tb/test_pmem_word_xfer.sv
module test_pmem_word_xfer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_start = 1'b0;
  logic [1:0]  op_code = 2'b00;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [23:0] addr_o;
  logic [7:0]  data_hi_o, data_lo_o;
  logic        op_done, align_err, mem_re, mem_we;
  logic [22:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  typedef struct {
    int          kind;   // 0 read, 1 write, 2 alignment error
    int          due;
    string       req;
    logic [23:0] addr;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [22:0] maddr;
    logic [15:0] wdata;
  } item_t;
  item_t q[$];

  logic [15:0] ram [256];
  logic [15:0] mdl [256];
  logic [23:0] e_addr;
  logic [7:0]  e_hi, e_lo;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr[7:0]];
  end

  pmem_word_xfer i_pmem_word_xfer (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .addr_o(addr_o), .data_hi_o(data_hi_o), .data_lo_o(data_lo_o),
    .op_done(op_done), .align_err(align_err), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares observed events with the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (q.size() == 0 || q[0].kind != 1) chk("R4 unexpected mem_we", 1, 0);
        else begin
          chk({q[0].req, " mem_we cycle"}, cyc, q[0].due - 1);
          chk({q[0].req, " mem_addr"}, {9'd0, mem_addr}, {9'd0, q[0].maddr});
          chk({q[0].req, " mem_wdata"}, {16'd0, mem_wdata}, {16'd0, q[0].wdata});
        end
      end
      if (op_done || align_err) begin
        if (q.size() == 0) chk("R9 unexpected event", 1, 0);
        else begin
          item_t it;
          it = q.pop_front();
          chk({it.req, " event kind"}, {30'd0, align_err, op_done},
              (it.kind == 2) ? 32'd2 : 32'd1);
          chk({it.req, " event cycle"}, cyc, it.due);
          chk({it.req, " addr"}, {8'd0, addr_o}, {8'd0, it.addr});
          chk({it.req, " data"}, {16'd0, data_hi_o, data_lo_o}, {16'd0, it.hi, it.lo});
        end
      end
    end
  end

  task automatic reg_wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (sel)
      3'd0: e_addr[7:0]   = d;
      3'd1: e_addr[15:8]  = d;
      3'd2: e_addr[23:16] = d;
      3'd3: e_lo = d;
      3'd4: e_hi = d;
      default: ;
    endcase
  endtask

  task automatic set_addr(input logic [23:0] a);
    reg_wr(3'd0, a[7:0]);
    reg_wr(3'd1, a[15:8]);
    reg_wr(3'd2, a[23:16]);
  endtask

  // driver: pushes the expected result then strobes the operation
  task automatic do_op(input logic [1:0] op, input string req, input bit busy_poke);
    item_t it;
    @(negedge clk);
    it.req = req;
    it.maddr = e_addr[23:1];
    it.wdata = {e_hi, e_lo};
    if (e_addr[0]) begin
      it.kind = 2; it.due = cyc + 1;
    end else if (op[1]) begin
      it.kind = 1; it.due = cyc + 2;
      mdl[e_addr[8:1]] = {e_hi, e_lo};
      if (op[0]) e_addr = e_addr + 24'd2;
    end else begin
      it.kind = 0; it.due = cyc + 3;
      {e_hi, e_lo} = mdl[e_addr[8:1]];
      if (op[0]) e_addr = e_addr + 24'd2;
    end
    it.addr = e_addr; it.hi = e_hi; it.lo = e_lo;
    q.push_back(it);
    op_start = 1'b1; op_code = op;
    @(negedge clk);
    op_start = 1'b0;
    if (busy_poke) begin
      // R8 / R9: strobe and register write while busy, both ignored
      op_start = 1'b1; op_code = 2'b10;
      reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 8'hEE;
      @(negedge clk);
      op_start = 1'b0; reg_we = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
      mdl[i] = ram[i];
    end
    e_addr = '0; e_hi = '0; e_lo = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 addr", {8'd0, addr_o}, 0);
    chk("R1 data", {16'd0, data_hi_o, data_lo_o}, 0);
    chk("R1 flags", {28'd0, op_done, align_err, mem_re, mem_we}, 0);

    // R2 / R3: plain read, address held
    set_addr(24'h000010);
    do_op(2'b00, "R3 read", 1'b0);
    chk("R5 no step", {8'd0, addr_o}, 32'h10);
    // R5: reads with step
    do_op(2'b01, "R5 read step a", 1'b0);
    do_op(2'b01, "R5 read step b", 1'b0);
    // R4: write then read back, R8 data byte writes
    reg_wr(3'd4, 8'hC3);
    reg_wr(3'd3, 8'h7E);
    chk("R8 data bytes", {16'd0, data_hi_o, data_lo_o}, 32'hC37E);
    set_addr(24'h000040);
    do_op(2'b10, "R4 write", 1'b0);
    do_op(2'b00, "R4 readback", 1'b0);
    reg_wr(3'd4, 8'h12);
    reg_wr(3'd3, 8'h34);
    do_op(2'b11, "R4 write step", 1'b0);
    set_addr(24'h000040);
    do_op(2'b01, "R2 read step x", 1'b0);
    do_op(2'b01, "R2 read step y", 1'b0);
    // R6: carries and wrap
    set_addr(24'h0000FE);
    do_op(2'b01, "R6 carry byte1", 1'b0);
    set_addr(24'h00FFFE);
    do_op(2'b01, "R6 carry byte2", 1'b0);
    set_addr(24'hFFFFFE);
    do_op(2'b11, "R6 wrap", 1'b0);
    chk("R6 wrapped addr", {8'd0, addr_o}, 0);
    // R7: misaligned read and write
    set_addr(24'h000021);
    do_op(2'b01, "R7 misaligned read", 1'b0);
    do_op(2'b11, "R7 misaligned write", 1'b0);
    chk("R7 addr kept", {8'd0, addr_o}, 32'h21);
    // R8 / R9: pokes while busy are ignored
    set_addr(24'h000030);
    do_op(2'b00, "R9 busy read", 1'b1);
    chk("R8 busy write ignored", {24'd0, data_hi_o}, {24'd0, e_hi});
    do_op(2'b10, "R9 busy write", 1'b1);
    chk("R8 hi after busy write", {24'd0, data_hi_o}, {24'd0, e_hi});
    repeat (5) @(negedge clk);
    chk("R9 queue drained", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule